// File: doc/BRIEF.md
# Configuration CRC Guard

This block protects a small bank of configuration registers with an 8-bit CRC and feeds the result into a safety state machine. Software writes the protected registers and a reference CRC byte through a simple byte-wide register port. It then sets a check-enable bit. On that 0-to-1 transition the block scans the bank once and compares the result with the reference byte. The outcome stays latched and does not track later register changes. To get a fresh verdict, software clears the enable bit and sets it again.

A second scan covers an EEPROM image presented as a flat input vector, compared against an expected CRC byte. Software starts it by writing a one to a request bit. A small supervisor decides when the driver-enable output may be high. It also decides when the block must drop into an absorbing SAFE condition: after a failing configuration check is abandoned in DIAGNOSTIC mode, or after an EEPROM mismatch found in DIAGNOSTIC mode.

The scan engine has three states. SCAN_IDLE waits for a start. SCAN_CFG feeds one configuration byte per clock. SCAN_EE feeds one image byte per clock. Both scan states return to SCAN_IDLE after their last byte.

The supervisor also has three states. SUP_LOCKED (after reset, driver off) moves to SUP_RUNNING when the mode input reads ACTIVE. SUP_LOCKED or SUP_RUNNING moves to SUP_SAFE on either trip condition. SUP_SAFE has no exit other than reset.

Top module: `cfg_crc_guard`

## Requirements
- R1: The configuration CRC is computed as follows. The polynomial is x^8+x^2+x+1 (0x07) and the start value is 0xFF. Registers are fed in ascending address order, one byte per clock, most significant bit first, with no final inversion. The result is compared with the reference byte, and `cfg_crc_err` is 1 exactly when they differ.
- R2: A configuration scan starts only on an accepted control write that moves the enable bit (control bit 0) from 0 to 1. Writing 1 while the bit is already 1 starts nothing.
- R3: After a scan has finished, writes to protected registers or to the reference byte leave `cfg_crc_err` and `ee_crc_err` unchanged until another scan completes.
- R4: The address map is: protected registers at 0..NUM_CFG_REGS-1, the reference byte at NUM_CFG_REGS, and the control register at NUM_CFG_REGS+1. Writes to the protected registers and to the reference byte take effect only when `mode` is 2'b00 (DIAGNOSTIC). They are ignored for 2'b01 (ACTIVE), 2'b10 and 2'b11 (SAFE). All three are readable on `reg_rdata` in the same cycle.
- R5: An accepted control write can clear the enable bit while `cfg_crc_err` is 1 and `mode` is DIAGNOSTIC. When that happens, `safe_req` is 1 and `drv_en` is 0 from the next cycle.
- R6: An accepted control write with bit 1 set starts an EEPROM scan, unless the same write starts a configuration scan. The scan uses the same CRC and covers `ee_image` byte 0 (bits 7:0) upward. `ee_crc_err` is 1 when the result differs from `ee_expected`.
- R7: An EEPROM scan that ends with `ee_crc_err` set while `mode` is DIAGNOSTIC raises `safe_req` in the same cycle `busy` falls. In any other mode it does not raise `safe_req`.
- R8: Suppose `cfg_crc_err` is 1 and the EEPROM scan is started by a write that leaves the enable bit at 0. Then `ee_crc_err` is set even when the image matches.
- R9: `busy` is high for exactly NUM_CFG_REGS cycles for a configuration scan and EE_BYTES cycles for an EEPROM scan. The error flags hold their new value in the first cycle `busy` is low. Control writes made while `busy` is high are dropped entirely. Control bit 1 reads back `busy`.
- R10: Once `safe_req` is 1 it stays 1 and `drv_en` stays 0, regardless of mode or later checks, until reset.
- R11: Reset clears both error flags, the enable bit, `safe_req` and `drv_en`. `drv_en` rises one cycle after `mode` reads ACTIVE, provided SAFE has not been entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Device mode: 00 DIAGNOSTIC, 01 ACTIVE, 10/11 SAFE |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ee_image | input | 8*EE_BYTES | EEPROM image, byte 0 in the low bits |
| ee_expected | input | 8 | Expected CRC of the EEPROM image |
| busy | output | 1 | A scan is running |
| cfg_crc_err | output | 1 | Latched configuration CRC mismatch |
| ee_crc_err | output | 1 | Latched EEPROM CRC mismatch |
| safe_req | output | 1 | Request to enter SAFE (absorbing) |
| drv_en | output | 1 | Driver enable |

## Verification
The bench builds the block with four protected registers and a two-byte image. This keeps each scan short enough to sweep the reference byte and the expected byte over all 256 values for several register and image contents, so every mismatch and the single match are seen. The small sizes also make the scan length, dropped writes during a scan, and the sticky-result, forced-error and SAFE trip sequences cheap to reach one after another with resets between them.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;

    typedef enum logic [1:0] {
        MODE_DIAG     = 2'b00,
        MODE_ACTIVE   = 2'b01,
        MODE_SAFE     = 2'b10,
        MODE_SAFE_ALT = 2'b11
    } dev_mode_e;

    typedef enum logic [1:0] {
        SCAN_IDLE = 2'b00,
        SCAN_CFG  = 2'b01,
        SCAN_EE   = 2'b10
    } scan_state_e;

    typedef enum logic [1:0] {
        SUP_LOCKED  = 2'b00,
        SUP_RUNNING = 2'b01,
        SUP_SAFE    = 2'b10
    } sup_state_e;

    localparam logic [7:0] CRC_POLY = 8'h07;
    localparam logic [7:0] CRC_SEED = 8'hFF;

    // One byte through the CRC8 divider, most significant bit first.
    function automatic logic [7:0] crc8_byte(input logic [7:0] crc_in, input logic [7:0] data);
        logic [7:0] r;
        r = crc_in ^ data;
        for (int b = 0; b < 8; b++) begin
            r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/cfgcrc_bank.sv
module cfgcrc_bank #(
    parameter int NUM_CFG_REGS = 8,
    parameter int ADDR_W       = 4,
    parameter int IDX_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              diag_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [IDX_W-1:0]  scan_idx,
    output logic [7:0]        rdata,
    output logic [7:0]        scan_byte,
    output logic [7:0]        stored_crc
);
    localparam int STORE_ADDR = NUM_CFG_REGS;

    logic [7:0] cfg_q [NUM_CFG_REGS];
    logic [7:0] store_q;

    // Protected registers: writable only in DIAGNOSTIC (R4)
    for (genvar g = 0; g < NUM_CFG_REGS; g++) begin : g_cfg_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= 8'h00;
            end else if (wr_en && diag_mode && addr == ADDR_W'(g)) begin
                cfg_q[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= 8'h00;
        end else if (wr_en && diag_mode && addr == ADDR_W'(STORE_ADDR)) begin
            store_q <= wdata;
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (addr == ADDR_W'(STORE_ADDR)) begin
            rdata = store_q;
        end
        for (int i = 0; i < NUM_CFG_REGS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = cfg_q[i];
            end
        end
    end

    always_comb begin
        scan_byte = 8'h00;
        for (int i = 0; i < NUM_CFG_REGS; i++) begin
            if (scan_idx == IDX_W'(i)) begin
                scan_byte = cfg_q[i];
            end
        end
    end

    assign stored_crc = store_q;

endmodule

// File: rtl/cfgcrc_engine.sv
module cfgcrc_engine
    import cfgcrc_pkg::*;
#(
    parameter int NUM_CFG_REGS = 8,
    parameter int EE_BYTES     = 4,
    parameter int IDX_W        = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_cfg,
    input  logic                  start_ee,
    input  logic                  force_ee,
    input  logic [7:0]            cfg_byte,
    input  logic [7:0]            stored_crc,
    input  logic [8*EE_BYTES-1:0] ee_image,
    input  logic [7:0]            ee_expected,
    output logic [IDX_W-1:0]      scan_idx,
    output logic                  busy,
    output logic                  cfg_err,
    output logic                  ee_err,
    output logic                  ee_fail
);
    localparam logic [IDX_W-1:0] CFG_LAST = IDX_W'(NUM_CFG_REGS - 1);
    localparam logic [IDX_W-1:0] EE_LAST  = IDX_W'(EE_BYTES - 1);

    scan_state_e      state_q, state_nx;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       crc_q, crc_nx;
    logic [7:0]       ee_byte, feed_byte;
    logic             force_q, cfg_err_q, ee_err_q;
    logic             last_byte, ee_mismatch;

    always_comb begin
        ee_byte = 8'h00;
        for (int k = 0; k < EE_BYTES; k++) begin
            if (idx_q == IDX_W'(k)) begin
                ee_byte = ee_image[k*8 +: 8];
            end
        end
    end

    assign feed_byte   = (state_q == SCAN_EE) ? ee_byte : cfg_byte;
    assign crc_nx      = crc8_byte(crc_q, feed_byte);
    assign last_byte   = ((state_q == SCAN_CFG) && (idx_q == CFG_LAST)) ||
                         ((state_q == SCAN_EE)  && (idx_q == EE_LAST));
    assign ee_mismatch = (crc_nx != ee_expected) || force_q;

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SCAN_IDLE: begin
                if (start_cfg)     state_nx = SCAN_CFG;
                else if (start_ee) state_nx = SCAN_EE;
            end
            SCAN_CFG: if (last_byte) state_nx = SCAN_IDLE;
            SCAN_EE:  if (last_byte) state_nx = SCAN_IDLE;
            default:  state_nx = SCAN_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SCAN_IDLE;
        else        state_q <= state_nx;
    end

    // Datapath and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            crc_q     <= CRC_SEED;
            force_q   <= 1'b0;
            cfg_err_q <= 1'b0;
            ee_err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                SCAN_IDLE: begin
                    idx_q <= '0;
                    crc_q <= CRC_SEED;
                    if (start_ee && !start_cfg) force_q <= force_ee;
                end
                SCAN_CFG: begin
                    idx_q <= idx_q + 1'b1;
                    crc_q <= crc_nx;
                    if (last_byte) cfg_err_q <= (crc_nx != stored_crc);
                end
                SCAN_EE: begin
                    idx_q <= idx_q + 1'b1;
                    crc_q <= crc_nx;
                    if (last_byte) ee_err_q <= ee_mismatch;
                end
                default: idx_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != SCAN_IDLE);
        scan_idx = idx_q;
        cfg_err  = cfg_err_q;
        ee_err   = ee_err_q;
        ee_fail  = (state_q == SCAN_EE) && last_byte && ee_mismatch;
    end

endmodule

// File: rtl/cfgcrc_supervisor.sv
module cfgcrc_supervisor
    import cfgcrc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       ctrl_wr,
    input  logic       wr_en_bit,
    input  logic       wr_chk_bit,
    input  logic       busy,
    input  logic       cfg_err,
    input  logic       ee_fail,
    output logic       cfg_en,
    output logic       start_cfg,
    output logic       start_ee,
    output logic       force_ee,
    output logic       safe_req,
    output logic       drv_en
);
    sup_state_e sup_q, sup_nx;
    logic       en_q;
    logic       ctrl_accept, in_diag, clear_trip, ee_trip, trip;

    assign in_diag     = (mode == MODE_DIAG);
    assign ctrl_accept = ctrl_wr && !busy;
    assign start_cfg   = ctrl_accept && wr_en_bit && !en_q;
    assign start_ee    = ctrl_accept && wr_chk_bit && !start_cfg;
    assign force_ee    = cfg_err && !wr_en_bit;
    assign clear_trip  = ctrl_accept && en_q && !wr_en_bit && cfg_err && in_diag;
    assign ee_trip     = ee_fail && in_diag;
    assign trip        = clear_trip || ee_trip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           en_q <= 1'b0;
        else if (ctrl_accept) en_q <= wr_en_bit;
    end

    always_comb begin
        sup_nx = sup_q;
        unique case (sup_q)
            SUP_LOCKED: begin
                if (trip)                     sup_nx = SUP_SAFE;
                else if (mode == MODE_ACTIVE) sup_nx = SUP_RUNNING;
            end
            SUP_RUNNING: if (trip) sup_nx = SUP_SAFE;
            SUP_SAFE:    sup_nx = SUP_SAFE;
            default:     sup_nx = SUP_SAFE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sup_q <= SUP_LOCKED;
        else        sup_q <= sup_nx;
    end

    // Outputs
    always_comb begin
        cfg_en   = en_q;
        drv_en   = (sup_q == SUP_RUNNING);
        safe_req = (sup_q == SUP_SAFE);
    end

endmodule

// File: rtl/cfg_crc_guard.sv
module cfg_crc_guard
    import cfgcrc_pkg::*;
#(
    parameter int   NUM_CFG_REGS = 8,
    parameter int   EE_BYTES     = 4,
    localparam int  ADDR_W       = $clog2(NUM_CFG_REGS + 2)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic [8*EE_BYTES-1:0] ee_image,
    input  logic [7:0]            ee_expected,
    output logic                  busy,
    output logic                  cfg_crc_err,
    output logic                  ee_crc_err,
    output logic                  safe_req,
    output logic                  drv_en
);
    localparam int SCAN_MAX  = (NUM_CFG_REGS > EE_BYTES) ? NUM_CFG_REGS : EE_BYTES;
    localparam int IDX_W     = (SCAN_MAX > 1) ? $clog2(SCAN_MAX) : 1;
    localparam int CTRL_ADDR = NUM_CFG_REGS + 1;

    logic [IDX_W-1:0] scan_idx;
    logic [7:0]       bank_rdata, scan_byte, stored_crc;
    logic             ctrl_wr, cfg_en, start_cfg, start_ee, force_ee, ee_fail;
    logic             busy_w, cfg_err_w, ee_err_w;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));

    cfgcrc_bank #(
        .NUM_CFG_REGS (NUM_CFG_REGS),
        .ADDR_W       (ADDR_W),
        .IDX_W        (IDX_W)
    ) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .diag_mode  (mode == MODE_DIAG),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .scan_idx   (scan_idx),
        .rdata      (bank_rdata),
        .scan_byte  (scan_byte),
        .stored_crc (stored_crc)
    );

    cfgcrc_engine #(
        .NUM_CFG_REGS (NUM_CFG_REGS),
        .EE_BYTES     (EE_BYTES),
        .IDX_W        (IDX_W)
    ) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_cfg   (start_cfg),
        .start_ee    (start_ee),
        .force_ee    (force_ee),
        .cfg_byte    (scan_byte),
        .stored_crc  (stored_crc),
        .ee_image    (ee_image),
        .ee_expected (ee_expected),
        .scan_idx    (scan_idx),
        .busy        (busy_w),
        .cfg_err     (cfg_err_w),
        .ee_err      (ee_err_w),
        .ee_fail     (ee_fail)
    );

    cfgcrc_supervisor i_supervisor (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .ctrl_wr    (ctrl_wr),
        .wr_en_bit  (reg_wdata[0]),
        .wr_chk_bit (reg_wdata[1]),
        .busy       (busy_w),
        .cfg_err    (cfg_err_w),
        .ee_fail    (ee_fail),
        .cfg_en     (cfg_en),
        .start_cfg  (start_cfg),
        .start_ee   (start_ee),
        .force_ee   (force_ee),
        .safe_req   (safe_req),
        .drv_en     (drv_en)
    );

    assign reg_rdata   = (reg_addr == ADDR_W'(CTRL_ADDR)) ? {6'b0, busy_w, cfg_en} : bank_rdata;
    assign busy        = busy_w;
    assign cfg_crc_err = cfg_err_w;
    assign ee_crc_err  = ee_err_w;

endmodule

// File: rtl/cfgcrc_checker.sv
module cfgcrc_checker #(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wr_bit0,
    input logic              busy,
    input logic              cfg_en,
    input logic              cfg_crc_err,
    input logic              ee_crc_err,
    input logic              safe_req,
    input logic              drv_en
);
    logic ctrl_hit;
    assign ctrl_hit = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));

    // R3: flags only move when a scan finishes
    assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ctrl_hit) |=> ($stable(cfg_crc_err) && $stable(ee_crc_err)));

    // R5: abandoning a failing check in DIAGNOSTIC trips SAFE
    assert_clear_trips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && !busy && cfg_en && !wr_bit0 && cfg_crc_err && mode == 2'b00) |=> (safe_req && !drv_en));

    // R9: control writes during a scan are dropped
    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_hit) |=> $stable(cfg_en));

    // R10: SAFE is absorbing and keeps the driver off
    assert_safe_absorb_R10: assert property (@(posedge clk) disable iff (!rst_n)
        safe_req |=> (safe_req && !drv_en));

    // R11: driver enable only follows ACTIVE mode
    assert_drv_needs_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> ($past(mode) == 2'b01));

endmodule

bind cfg_crc_guard cfgcrc_checker #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR)
) i_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .wr_bit0     (reg_wdata[0]),
    .busy        (busy),
    .cfg_en      (cfg_en),
    .cfg_crc_err (cfg_crc_err),
    .ee_crc_err  (ee_crc_err),
    .safe_req    (safe_req),
    .drv_en      (drv_en)
);

// File: tb/test_cfg_crc_guard.sv
`timescale 1ns/1ps
module test_cfg_crc_guard;
    localparam int N      = 4;
    localparam int EB     = 2;
    localparam int AW     = $clog2(N + 2);
    localparam int STORE  = N;
    localparam int CTRL   = N + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [8*EB-1:0] ee_image = '0;
    logic [7:0]    ee_expected = 8'h00;
    logic          busy, cfg_crc_err, ee_crc_err, safe_req, drv_en;

    int checks = 0;
    int fails  = 0;
    logic [7:0] regs [N];

    always #2 clk = ~clk;

    cfg_crc_guard #(.NUM_CFG_REGS(N), .EE_BYTES(EB)) i_cfg_crc_guard (
        .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ee_image(ee_image),
        .ee_expected(ee_expected), .busy(busy), .cfg_crc_err(cfg_crc_err),
        .ee_crc_err(ee_crc_err), .safe_req(safe_req), .drv_en(drv_en)
    );

    // Independent CRC8: polynomial 0x07, seed 0xFF, MSB first
    function automatic logic [7:0] ref_step(input logic [7:0] c, input logic [7:0] d);
        logic [15:0] acc;
        acc = {c ^ d, 8'h00};
        for (int b = 15; b >= 8; b--) begin
            if (acc[b]) acc = acc ^ (16'h0107 << (b - 8));
        end
        return acc[7:0];
    endfunction

    function automatic logic [7:0] ref_cfg_crc();
        logic [7:0] c = 8'hFF;
        for (int i = 0; i < N; i++) c = ref_step(c, regs[i]);
        return c;
    endfunction

    function automatic logic [7:0] ref_ee_crc(input logic [8*EB-1:0] img);
        logic [7:0] c = 8'hFF;
        for (int k = 0; k < EB; k++) c = ref_step(c, img[k*8 +: 8]);
        return c;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 1'b0; mode = 2'b00;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load_regs(input int p);
        for (int i = 0; i < N; i++) begin
            regs[i] = 8'((p * 37 + i * 11 + 5) & 255);
            wr(i, regs[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d, c;
        int cnt;
        do_reset();

        // R11 reset state
        rd(CTRL, d);
        check(cfg_crc_err == 0 && ee_crc_err == 0, "R11 flags after reset", {cfg_crc_err, ee_crc_err}, 0);
        check(safe_req == 0 && drv_en == 0, "R11 safe/drv after reset", {safe_req, drv_en}, 0);
        check(d[0] == 0, "R11 enable after reset", d, 0);

        // R4 write gating by mode
        load_regs(1);
        wr(STORE, 8'h5A);
        for (int m = 1; m < 4; m++) begin
            mode = 2'(m);
            wr(2, 8'hEE);
            wr(STORE, 8'h11);
            rd(2, d);
            check(d == regs[2], "R4 protected write ignored", d, regs[2]);
            rd(STORE, d);
            check(d == 8'h5A, "R4 reference write ignored", d, 8'h5A);
        end
        rd(2, d);
        check(d == regs[2], "R4 DIAG write readback", d, regs[2]);
        // R11 drv_en rises one cycle after ACTIVE
        @(negedge clk); mode = 2'b01;
        @(negedge clk);
        check(drv_en == 1, "R11 drv_en after ACTIVE", drv_en, 1);

        // R1 exhaustive reference sweep
        for (int p = 0; p < 3; p++) begin
            do_reset();
            load_regs(p + 2);
            c = ref_cfg_crc();
            for (int s = 0; s < 256; s++) begin
                wr(STORE, 8'(s));
                wr(CTRL, 8'h00);
                wr(CTRL, 8'h01);
                wait_idle();
                check(cfg_crc_err == (8'(s) != c), "R1 cfg crc compare", cfg_crc_err, (8'(s) != c));
            end
        end

        // R2/R3 sticky result
        do_reset();
        load_regs(7);
        c = ref_cfg_crc();
        wr(STORE, c);
        wr(CTRL, 8'h01);
        wait_idle();
        check(cfg_crc_err == 0, "R1 matching crc", cfg_crc_err, 0);
        wr(STORE, c ^ 8'h01);
        wr(0, regs[0] ^ 8'h80);
        repeat (10) @(negedge clk);
        check(cfg_crc_err == 0 && busy == 0, "R3 no re-evaluation", cfg_crc_err, 0);
        regs[0] = regs[0] ^ 8'h80;
        wr(0, regs[0]);
        wr(CTRL, 8'h00);
        wr(CTRL, 8'h01);
        wait_idle();
        check(cfg_crc_err == 1, "R3 toggle gives fresh result", cfg_crc_err, 1);
        wr(STORE, ref_cfg_crc());
        wr(CTRL, 8'h01);
        check(busy == 0, "R2 no start while enabled", busy, 0);
        repeat (8) @(negedge clk);
        check(cfg_crc_err == 1, "R2 flag kept without edge", cfg_crc_err, 1);

        // R9 busy length and dropped writes
        do_reset();
        load_regs(9);
        wr(CTRL, 8'h01);
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == N, "R9 cfg busy length", cnt, N);
        wr(CTRL, 8'h00);
        wr(CTRL, 8'h01);
        wr(CTRL, 8'h00);
        wait_idle();
        rd(CTRL, d);
        check(d[1:0] == 2'b01, "R9 write during busy dropped", d, 1);
        wr(CTRL, 8'h03);
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == EB, "R9 ee busy length", cnt, EB);

        // R6 exhaustive expected-byte sweep in ACTIVE, R7 negative
        for (int p = 0; p < 2; p++) begin
            do_reset();
            mode = 2'b01;
            ee_image = 16'(p * 16'h9C35 + 16'h1234);
            c = ref_ee_crc(ee_image);
            for (int s = 0; s < 256; s++) begin
                ee_expected = 8'(s);
                wr(CTRL, 8'h02);
                wait_idle();
                check(ee_crc_err == (8'(s) != c), "R6 ee crc compare", ee_crc_err, (8'(s) != c));
            end
            check(safe_req == 0 && drv_en == 1, "R7 no trip outside DIAG", safe_req, 0);
        end

        // R5 clearing a failing check
        do_reset();
        load_regs(4);
        wr(STORE, ref_cfg_crc() ^ 8'h40);
        wr(CTRL, 8'h01);
        wait_idle();
        check(cfg_crc_err == 1 && safe_req == 0, "R5 error without trip", {cfg_crc_err, safe_req}, 2);
        @(negedge clk); mode = 2'b01;
        wr(CTRL, 8'h00);
        check(safe_req == 0 && drv_en == 1, "R5 clear in ACTIVE no trip", safe_req, 0);
        wr(CTRL, 8'h01);
        wait_idle();
        @(negedge clk); mode = 2'b00;
        wr(CTRL, 8'h00);
        check(safe_req == 1 && drv_en == 0, "R5 clear in DIAG trips", {safe_req, drv_en}, 2);
        @(negedge clk); mode = 2'b01;
        repeat (4) @(negedge clk);
        check(safe_req == 1 && drv_en == 0, "R10 SAFE absorbing", {safe_req, drv_en}, 2);

        // R8 forced EEPROM error
        do_reset();
        ee_image = 16'hA55A;
        ee_expected = ref_ee_crc(ee_image);
        load_regs(5);
        wr(STORE, ref_cfg_crc() ^ 8'h02);
        wr(CTRL, 8'h01);
        wait_idle();
        wr(CTRL, 8'h03);
        wait_idle();
        check(ee_crc_err == 0, "R8 no force while enabled", ee_crc_err, 0);
        @(negedge clk); mode = 2'b01;
        wr(CTRL, 8'h00);
        wr(CTRL, 8'h02);
        wait_idle();
        check(ee_crc_err == 1, "R8 forced ee error", ee_crc_err, 1);
        check(safe_req == 0, "R7 forced error in ACTIVE no trip", safe_req, 0);

        // R7 EEPROM error in DIAG
        do_reset();
        ee_expected = ref_ee_crc(ee_image) ^ 8'h10;
        wr(CTRL, 8'h02);
        wait_idle();
        check(ee_crc_err == 1 && safe_req == 1, "R7 ee error trips in DIAG", {ee_crc_err, safe_req}, 3);
        ee_expected = ref_ee_crc(ee_image);
        wr(CTRL, 8'h02);
        wait_idle();
        check(ee_crc_err == 0 && safe_req == 1, "R10 passing check keeps SAFE", {ee_crc_err, safe_req}, 1);
        do_reset();
        check(safe_req == 0 && ee_crc_err == 0, "R11 reset leaves SAFE", {safe_req, ee_crc_err}, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule